// File: doc/BRIEF.md
# Soft-Start / Soft-Stop Reference Ramp Sequencer

This block steps the output-voltage reference of one regulator channel up and down. When the host raises the channel enable, the block waits a programmed start delay. It then moves the reference code toward the target, one 50 mV code at a time, and holds it there once the target is reached. When the enable drops, the block waits its own stop delay and moves the reference down to the discharge code one code at a time. It then reports the channel as off. A restart request from the fault supervisor aborts any sequence and starts a fresh one.

Each of the two sequences is described by one 16-bit timing word. The upper six bits are a delay counted in coarse units, where one unit is `UNIT_TICKS` pulses of the 1 µs tick. The lower ten bits are the dwell per code step, counted in 1 µs ticks. The block drives the reference code, an enable for the PWM drivers and a 3-bit sequence state. The DAC and the control loop that consume these outputs are outside the block.

Top module: `ramp_seq`

## Requirements
- R1: During reset the state output is 0, the reference code is 0 and the PWM enable is low.
- R2: The state output uses these codes: 0 idle, 1 start delay, 2 ramp up, 3 on, 4 stop delay, 5 ramp down. From idle, a high enable with no restart moves the block to the start delay on the next cycle. The start delay lasts start_cfg[15:10] × UNIT_TICKS ticks plus one cycle, and the reference does not change during it.
- R3: In ramp up, after every start_cfg[9:0] ticks the reference moves one code toward the target code. It lands exactly on the target, and the block enters the on state on the next cycle.
- R4: A step field of zero moves the reference to the endpoint of the ramp in a single cycle.
- R5: In the on state the reference holds. A low enable moves the block to the stop delay on the next cycle. The stop delay lasts stop_cfg[15:10] × UNIT_TICKS ticks plus one cycle. The enable is ignored from the stop delay until the block is idle.
- R6: In ramp down, after every stop_cfg[9:0] ticks the reference moves one code toward the discharge code. On reaching it the block goes idle. While idle, the reference equals the discharge code from the following cycle on.
- R7: A low enable during the start delay or during ramp up moves the block to the stop delay on the next cycle and keeps the current reference. The ramp down then starts from that reference. If a step is due in the same cycle as the disable, the disable wins and the step is dropped.
- R8: A restart request forces the idle state on the next cycle, with the reference at the discharge code and PWM disabled. The restart takes priority over a simultaneous disable. While the request is held the block stays idle. After the request is released, a high enable starts the start delay.
- R9: The PWM enable is high exactly in states 2 to 5, and it rises only when the block leaves the start delay.
- R10: The delay and step timers advance only in cycles where the tick input is high. With the tick held low, the state and the reference stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| chan_en | input | 1 | Host channel enable (level) |
| restart_req | input | 1 | Restart request from the fault supervisor |
| start_cfg | input | REG_W | Start timing word: delay units in [15:10], µs per step in [9:0] |
| stop_cfg | input | REG_W | Stop timing word, same layout |
| target_code | input | CODE_W | Final reference code of the ramp up |
| discharge_code | input | CODE_W | Final reference code of the ramp down |
| ref_code | output | CODE_W | Reference code, one unit = 50 mV |
| pwm_en | output | 1 | Enable for the PWM drivers |
| state_o | output | 3 | Sequence state code |

## Verification
Two events can land in the same cycle. A disable can arrive in exactly the cycle where a ramp-up step is due. A restart can arrive together with a disable while the channel is on. For the first case, the bench watches for a reference change, counts forward to the cycle where the dwell counter would next fire, and drops the enable there. The result is judged by a stop-delay state with an unchanged reference, followed by a ramp down with exactly the expected number of steps. For the second case, the bench drives both inputs together and requires idle rather than the stop delay.

// File: rtl/ramp_seq_pkg.sv
`timescale 1ns/1ps
package ramp_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF  = 3'd0,
        SEQ_SDLY = 3'd1,
        SEQ_RUP  = 3'd2,
        SEQ_ON   = 3'd3,
        SEQ_PDLY = 3'd4,
        SEQ_RDN  = 3'd5
    } seq_state_e;

    // States in which the power stage is switching
    function automatic logic drives_pwm(seq_state_e s);
        return (s == SEQ_RUP) || (s == SEQ_ON) || (s == SEQ_PDLY) || (s == SEQ_RDN);
    endfunction

endpackage

// File: rtl/ramp_seq_cfg.sv
`timescale 1ns/1ps
// Splits one timing word into a scaled delay and a per-step dwell
module ramp_seq_cfg #(
    parameter int REG_W      = 16,
    parameter int STEP_W     = 10,
    parameter int UNIT_TICKS = 250,
    parameter int CNT_W      = 14
) (
    input  logic [REG_W-1:0] cfg,
    output logic [CNT_W-1:0] dly_ticks,
    output logic [CNT_W-1:0] step_ticks,
    output logic             step_zero
);
    localparam int DLY_W = REG_W - STEP_W;

    logic [DLY_W-1:0]  dly_units;
    logic [STEP_W-1:0] step_us;

    always_comb begin
        dly_units  = cfg[REG_W-1:STEP_W];
        step_us    = cfg[STEP_W-1:0];
        dly_ticks  = CNT_W'(dly_units) * CNT_W'(UNIT_TICKS);
        step_ticks = CNT_W'(step_us);
        step_zero  = (step_us == '0);
    end
endmodule

// File: rtl/ramp_seq_tmr.sv
`timescale 1ns/1ps
// Loadable down-counter advanced by the microsecond tick
module ramp_seq_tmr #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             is_zero,
    output logic             is_one
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ramp_seq_step.sv
`timescale 1ns/1ps
// One-code move toward an endpoint, never past it
module ramp_seq_step #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] endp,
    output logic [CODE_W-1:0] nxt,
    output logic              at_end
);
    always_comb begin
        at_end = (cur == endp);
        if (cur < endp) begin
            nxt = cur + 1'b1;
        end else if (cur > endp) begin
            nxt = cur - 1'b1;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/ramp_seq.sv
`timescale 1ns/1ps
module ramp_seq
    import ramp_seq_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int REG_W      = 16,
    parameter int STEP_W     = 10,
    parameter int UNIT_TICKS = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              chan_en,
    input  logic              restart_req,
    input  logic [REG_W-1:0]  start_cfg,
    input  logic [REG_W-1:0]  stop_cfg,
    input  logic [CODE_W-1:0] target_code,
    input  logic [CODE_W-1:0] discharge_code,
    output logic [CODE_W-1:0] ref_code,
    output logic              pwm_en,
    output logic [2:0]        state_o
);
    localparam int DLY_W      = REG_W - STEP_W;
    localparam int DLY_TICK_W = DLY_W + $clog2(UNIT_TICKS + 1);
    localparam int CNT_W      = (DLY_TICK_W > STEP_W) ? DLY_TICK_W : STEP_W;

    typedef struct packed {
        seq_state_e        state;
        logic [CODE_W-1:0] ref_code;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    // Timing words decoded (start and stop share one decoder design)
    logic [CNT_W-1:0] up_dly, up_step, dn_dly, dn_step;
    logic             up_step_zero, dn_step_zero;

    ramp_seq_cfg #(.REG_W(REG_W), .STEP_W(STEP_W), .UNIT_TICKS(UNIT_TICKS), .CNT_W(CNT_W)) u_cfg_up (
        .cfg        (start_cfg),
        .dly_ticks  (up_dly),
        .step_ticks (up_step),
        .step_zero  (up_step_zero)
    );

    ramp_seq_cfg #(.REG_W(REG_W), .STEP_W(STEP_W), .UNIT_TICKS(UNIT_TICKS), .CNT_W(CNT_W)) u_cfg_dn (
        .cfg        (stop_cfg),
        .dly_ticks  (dn_dly),
        .step_ticks (dn_step),
        .step_zero  (dn_step_zero)
    );

    // Single countdown shared by delays and step dwell (phases are exclusive)
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero, tmr_one;

    ramp_seq_tmr #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .load     (tmr_load),
        .load_val (tmr_val),
        .is_zero  (tmr_zero),
        .is_one   (tmr_one)
    );

    // Next-code calculators toward each endpoint
    logic [CODE_W-1:0] up_next, dn_next;
    logic              up_done, dn_done;

    ramp_seq_step #(.CODE_W(CODE_W)) u_step_up (
        .cur    (cur_q.ref_code),
        .endp   (target_code),
        .nxt    (up_next),
        .at_end (up_done)
    );

    ramp_seq_step #(.CODE_W(CODE_W)) u_step_dn (
        .cur    (cur_q.ref_code),
        .endp   (discharge_code),
        .nxt    (dn_next),
        .at_end (dn_done)
    );

    logic step_due;
    assign step_due = tick_us && (tmr_one || tmr_zero);

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (restart_req) begin
            nxt_d.state    = SEQ_OFF;
            nxt_d.ref_code = discharge_code;
        end else begin
            unique case (cur_q.state)
                SEQ_OFF: begin
                    nxt_d.ref_code = discharge_code;
                    if (chan_en) begin
                        nxt_d.state = SEQ_SDLY;
                        tmr_load    = 1'b1;
                        tmr_val     = up_dly;
                    end
                end
                SEQ_SDLY: begin
                    if (!chan_en) begin
                        nxt_d.state = SEQ_PDLY;
                        tmr_load    = 1'b1;
                        tmr_val     = dn_dly;
                    end else if (tmr_zero) begin
                        nxt_d.state = SEQ_RUP;
                        tmr_load    = 1'b1;
                        tmr_val     = up_step;
                    end
                end
                SEQ_RUP: begin
                    if (!chan_en) begin
                        nxt_d.state = SEQ_PDLY;
                        tmr_load    = 1'b1;
                        tmr_val     = dn_dly;
                    end else if (up_done) begin
                        nxt_d.state = SEQ_ON;
                    end else if (up_step_zero) begin
                        nxt_d.ref_code = target_code;
                    end else if (step_due) begin
                        nxt_d.ref_code = up_next;
                        tmr_load       = 1'b1;
                        tmr_val        = up_step;
                    end
                end
                SEQ_ON: begin
                    if (!chan_en) begin
                        nxt_d.state = SEQ_PDLY;
                        tmr_load    = 1'b1;
                        tmr_val     = dn_dly;
                    end
                end
                SEQ_PDLY: begin
                    if (tmr_zero) begin
                        nxt_d.state = SEQ_RDN;
                        tmr_load    = 1'b1;
                        tmr_val     = dn_step;
                    end
                end
                SEQ_RDN: begin
                    if (dn_done) begin
                        nxt_d.state = SEQ_OFF;
                    end else if (dn_step_zero) begin
                        nxt_d.ref_code = discharge_code;
                    end else if (step_due) begin
                        nxt_d.ref_code = dn_next;
                        tmr_load       = 1'b1;
                        tmr_val        = dn_step;
                    end
                end
                default: begin
                    nxt_d.state    = SEQ_OFF;
                    nxt_d.ref_code = discharge_code;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state    <= SEQ_OFF;
            cur_q.ref_code <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ref_code = cur_q.ref_code;
    assign state_o  = cur_q.state;
    assign pwm_en   = drives_pwm(cur_q.state);
endmodule

// File: rtl/ramp_seq_chk.sv
`timescale 1ns/1ps
module ramp_seq_chk #(
    parameter int CODE_W = 8,
    parameter int STEP_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart_req,
    input logic              chan_en,
    input logic [CODE_W-1:0] target_code,
    input logic [CODE_W-1:0] discharge_code,
    input logic [CODE_W-1:0] ref_code,
    input logic              pwm_en,
    input logic [2:0]        state_o,
    input logic [STEP_W-1:0] start_step
);
    // R8
    restart_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (state_o == 3'd0 && !pwm_en && ref_code == $past(discharge_code)));

    // R3
    up_step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && $past(state_o) == 3'd2 && start_step != '0 && $stable(start_step))
        |-> (ref_code == $past(ref_code) || ref_code == $past(ref_code) + 1'b1
             || ref_code == $past(ref_code) - 1'b1));

    // R3
    reach_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && ref_code == target_code && chan_en && !restart_req) |=> state_o == 3'd3);

    // R7
    delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !restart_req) |=> $stable(ref_code));

    // R9
    pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_en) |-> $past(state_o) == 3'd1);

    // R5
    on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && !chan_en && !restart_req) |=> state_o == 3'd4);

    // R2
    off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && chan_en && !restart_req) |=> state_o == 3'd1);
endmodule

bind ramp_seq ramp_seq_chk #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .restart_req    (restart_req),
    .chan_en        (chan_en),
    .target_code    (target_code),
    .discharge_code (discharge_code),
    .ref_code       (ref_code),
    .pwm_en         (pwm_en),
    .state_o        (state_o),
    .start_step     (start_cfg[STEP_W-1:0])
);

// File: tb/sim_ramp_seq.sv
`timescale 1ns/1ps
module sim_ramp_seq;
    localparam int CW = 5;
    localparam int UT = 2;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic          en;
    logic          rreq;
    logic [RW-1:0] scfg, pcfg;
    logic [CW-1:0] tgt, dis;
    logic [CW-1:0] rc;
    logic          pwm;
    logic [2:0]    st;

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    ramp_seq #(.CODE_W(CW), .REG_W(RW), .STEP_W(10), .UNIT_TICKS(UT)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_us        (tick),
        .chan_en        (en),
        .restart_req    (rreq),
        .start_cfg      (scfg),
        .stop_cfg       (pcfg),
        .target_code    (tgt),
        .discharge_code (dis),
        .ref_code       (rc),
        .pwm_en         (pwm),
        .state_o        (st)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic bit exp_pwm(input logic [2:0] s);
        return (s >= 3'd2) && (s <= 3'd5);
    endfunction

    function automatic int ramp_cyc(input int n, input int s);
        if (n == 0) return 1;
        if (s == 0) return 2;
        return n * s + 1;
    endfunction

    function automatic int ramp_chg(input int n, input int s);
        if (n == 0) return 0;
        if (s == 0) return 1;
        return n;
    endfunction

    // Counts samples spent in state s; records reference changes
    task automatic watch(input logic [2:0] s, output int ncyc, output int nchg,
                         output bit bad_jump, output bit bad_pwm);
        logic [CW-1:0] prev;
        ncyc = 0; nchg = 0; bad_jump = 1'b0; bad_pwm = 1'b0;
        prev = rc;
        while (st == s && ncyc < 5000) begin
            ncyc++;
            if (pwm !== exp_pwm(st)) bad_pwm = 1'b1;
            @(negedge clk);
            if (rc != prev) begin
                nchg++;
                if (absdiff(int'(rc), int'(prev)) > 1) bad_jump = 1'b1;
            end
            prev = rc;
        end
    endtask

    task automatic wait_st(input logic [2:0] s);
        for (int g = 0; g < 3000 && st != s; g++) @(negedge clk);
    endtask

    task automatic full_cycle(input int du, input int su, input int dd, input int sd,
                              input int t, input int d);
        int nc, ng, n;
        bit bj, bp, pwm_bad;
        pwm_bad = 1'b0;
        n = absdiff(t, d);
        scfg = {6'(du), 10'(su)};
        pcfg = {6'(dd), 10'(sd)};
        tgt = CW'(t);
        dis = CW'(d);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(st == 3'd0 && rc == CW'(d), "R6 idle level", int'(rc), d);
        en = 1'b1;
        @(negedge clk);
        chk(st == 3'd1, "R2 enter start delay", int'(st), 1);
        watch(3'd1, nc, ng, bj, bp);
        pwm_bad |= bp;
        chk(nc == du * UT + 1, "R2 start delay length", nc, du * UT + 1);
        chk(ng == 0, "R2 reference held in delay", ng, 0);
        watch(3'd2, nc, ng, bj, bp);
        pwm_bad |= bp;
        chk(nc == ramp_cyc(n, su), (su == 0) ? "R4 ramp-up cycles" : "R3 ramp-up cycles",
            nc, ramp_cyc(n, su));
        chk(ng == ramp_chg(n, su), (su == 0) ? "R4 ramp-up changes" : "R3 ramp-up changes",
            ng, ramp_chg(n, su));
        chk(su == 0 || !bj, "R3 single-code steps", int'(bj), 0);
        chk(st == 3'd3 && rc == CW'(t), "R3 lands on target", int'(rc), t);
        repeat (3) @(negedge clk);
        chk(st == 3'd3 && rc == CW'(t), "R5 on holds reference", int'(rc), t);
        if (pwm !== 1'b1) pwm_bad = 1'b1;
        en = 1'b0;
        @(negedge clk);
        chk(st == 3'd4, "R5 enter stop delay", int'(st), 4);
        watch(3'd4, nc, ng, bj, bp);
        pwm_bad |= bp;
        chk(nc == dd * UT + 1, "R5 stop delay length", nc, dd * UT + 1);
        watch(3'd5, nc, ng, bj, bp);
        pwm_bad |= bp;
        chk(nc == ramp_cyc(n, sd), (sd == 0) ? "R4 ramp-down cycles" : "R6 ramp-down cycles",
            nc, ramp_cyc(n, sd));
        chk(ng == ramp_chg(n, sd), "R6 ramp-down changes", ng, ramp_chg(n, sd));
        chk(st == 3'd0 && rc == CW'(d), "R6 ends idle at discharge", int'(rc), d);
        if (pwm !== 1'b0) pwm_bad = 1'b1;
        chk(!pwm_bad, "R9 pwm enable per state", int'(pwm_bad), 0);
    endtask

    initial begin
        int nc, ng, r;
        bit bj, bp;
        logic [CW-1:0] prev;
        rst_n = 1'b0; tick = 1'b1; en = 1'b0; rreq = 1'b0;
        scfg = '0; pcfg = '0; tgt = '0; dis = '0;
        repeat (3) @(negedge clk);
        chk(st == 3'd0, "R1 reset state", int'(st), 0);
        chk(rc == '0, "R1 reset reference", int'(rc), 0);
        chk(pwm == 1'b0, "R1 reset pwm", int'(pwm), 0);
        rst_n = 1'b1;
        dis = 5'd3;
        @(negedge clk);
        @(negedge clk);
        chk(rc == 5'd3, "R6 idle follows discharge", int'(rc), 3);

        // Near-exhaustive sweep of delay and step fields
        for (int du = 0; du < 4; du++) begin
            for (int su = 0; su < 4; su++) begin
                full_cycle(du, su, 3 - du, (su + 1) % 4,
                           (du * 7 + su * 3 + 1) % 12, (du * 2 + su * 5) % 10);
            end
        end

        // R10: tick gating in delay and ramp
        scfg = {6'd2, 10'd1}; pcfg = {6'd0, 10'd1}; tgt = 5'd2; dis = 5'd0;
        @(negedge clk);
        tick = 1'b0;
        en = 1'b1;
        @(negedge clk);
        nc = 0;
        while (st == 3'd1 && nc < 100) begin
            nc++;
            if (nc == 5) tick = 1'b1;
            @(negedge clk);
        end
        chk(nc == 2 * UT + 5, "R10 delay frozen without tick", nc, 2 * UT + 5);
        tick = 1'b0;
        repeat (6) @(negedge clk);
        chk(st == 3'd2 && rc == 5'd0, "R10 ramp frozen without tick", int'(rc), 0);
        tick = 1'b1;
        watch(3'd2, nc, ng, bj, bp);
        chk(st == 3'd3 && rc == 5'd2, "R10 ramp resumes", int'(rc), 2);
        en = 1'b0;
        wait_st(3'd0);

        // R7: disable during start delay
        dis = 5'd4; tgt = 5'd9; scfg = {6'd3, 10'd2}; pcfg = {6'd0, 10'd1};
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(st == 3'd4 && rc == 5'd4, "R7 disable in start delay", int'(st), 4);
        wait_st(3'd0);
        chk(rc == 5'd4, "R7 idle after aborted start", int'(rc), 4);

        // R7: disable in the cycle a ramp step is due
        dis = 5'd1; tgt = 5'd10; scfg = {6'd0, 10'd3}; pcfg = {6'd0, 10'd1};
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(st == 3'd2, "R7 ramp-up entered", int'(st), 2);
        prev = rc;
        for (int k = 0; k < 2; ) begin
            @(negedge clk);
            if (rc != prev) begin k++; prev = rc; end
        end
        repeat (2) @(negedge clk);
        r = int'(rc);
        chk(r == 3, "R3 reference after two steps", r, 3);
        en = 1'b0;
        @(negedge clk);
        chk(st == 3'd4 && int'(rc) == r, "R7 disable beats due step", int'(rc), r);
        watch(3'd4, nc, ng, bj, bp);
        watch(3'd5, nc, ng, bj, bp);
        chk(ng == r - 1, "R7 ramp down from current reference", ng, r - 1);
        chk(st == 3'd0 && rc == 5'd1, "R7 ends at discharge", int'(rc), 1);

        // R8: restart behaviour
        dis = 5'd2; tgt = 5'd5; scfg = {6'd0, 10'd1}; pcfg = {6'd0, 10'd1};
        en = 1'b1;
        wait_st(3'd3);
        rreq = 1'b1;
        @(negedge clk);
        chk(st == 3'd0 && rc == 5'd2 && !pwm, "R8 restart forces idle", int'(st), 0);
        rreq = 1'b0;
        @(negedge clk);
        chk(st == 3'd1, "R8 restart begins start delay", int'(st), 1);
        wait_st(3'd3);
        rreq = 1'b1;
        en = 1'b0;
        @(negedge clk);
        chk(st == 3'd0, "R8 restart beats disable", int'(st), 0);
        rreq = 1'b0;
        @(negedge clk);
        chk(st == 3'd0, "R8 stays idle when disabled", int'(st), 0);
        rreq = 1'b1;
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk(st == 3'd0, "R8 held restart keeps idle", int'(st), 0);
        rreq = 1'b0;
        @(negedge clk);
        chk(st == 3'd1, "R8 release starts sequence", int'(st), 1);
        en = 1'b0;
        wait_st(3'd0);

        // R5: enable ignored during stop sequence
        dis = 5'd0; tgt = 5'd3; scfg = {6'd0, 10'd1}; pcfg = {6'd2, 10'd1};
        en = 1'b1;
        wait_st(3'd3);
        en = 1'b0;
        @(negedge clk);
        chk(st == 3'd4, "R5 stop delay entered", int'(st), 4);
        en = 1'b1;
        watch(3'd4, nc, ng, bj, bp);
        chk(nc == 2 * UT + 1 && st == 3'd5, "R5 re-enable ignored in stop delay", nc, 2 * UT + 1);
        watch(3'd5, nc, ng, bj, bp);
        chk(st == 3'd0 && rc == 5'd0, "R5 ramp down completes", int'(rc), 0);
        @(negedge clk);
        chk(st == 3'd1, "R2 restart from idle with enable high", int'(st), 1);
        en = 1'b0;
        wait_st(3'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule